// File: doc/BRIEF.md
# Alarm Interrupt Status Register

This block keeps the interrupt state and the backup-battery state of a real-time clock that has a time-of-day alarm, and it drives the interrupt line. An external comparator sends a one-cycle match pulse when the time equals the alarm setting. The block latches that pulse into a request flag. Software clears the flag by reading or writing any alarm register.

A separate enable bit decides whether the request flag reaches the interrupt output. Two digital indications from analog comparators report the backup voltage: one for "above the upper threshold" and one for "below the lower threshold". Each is synchronized, and a hysteresis stage turns them into a low-battery flag. That flag holds its value while neither indication is active.

The status word is read from a fixed register address. It returns the low-battery flag and the request flag in fixed bit positions. Writes to the status address are ignored.

Top module: `rtc_irq_status`

## Requirements
- R1: `status_rdata` equals the status word when `bus_addr` equals the status address (default 0x0C) and 0 at every other address. In the status word, bit 6 is the low-battery flag, bit 0 is the request flag, and all other bits are 0.
- R2: A clock edge with `alarm_hit` high sets the request flag, which is visible after that edge.
- R3: `irq_out` is high exactly when the request flag is 1 and `irq_en` is 1. With `irq_en` low, `irq_out` stays low.
- R4: A clock edge with `bus_rd` or `bus_wr` high and `bus_addr` inside the alarm range (default 0x08 to 0x0B) clears the request flag.
- R5: When a match and a clearing alarm access fall on the same edge, the flag ends up set.
- R6: Writes to the status address leave both flags unchanged. Reads of the status address, and accesses outside the alarm range, do not clear the request flag.
- R7: After the third clock edge with `batt_low_in` high, the low-battery flag is 1. After the third edge with only `batt_ok_in` high, the flag is 0. With both inputs low, the flag holds its value. If both inputs are high, the low indication wins.
- R8: A clock edge with `rst_n` low clears the request flag and the low-battery flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_hit | input | 1 | One-cycle time/alarm match pulse |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| irq_en | input | 1 | Alarm interrupt enable |
| batt_ok_in | input | 1 | Backup voltage above upper threshold (asynchronous) |
| batt_low_in | input | 1 | Backup voltage below lower threshold (asynchronous) |
| status_rdata | output | 8 | Status read data |
| irq_out | output | 1 | Interrupt line, active high |

## Verification
The request flag is set first with the enable low and then with it high. This shows that gating happens at the output and not at the flag. The flag is then cleared through a read at the lowest alarm address and through a write at the highest one. Accesses are also made just below the alarm range and at the status address, to tell the range decode apart from a clear on any access.

A match that coincides with a clearing access checks the set-over-clear priority. The battery inputs are driven low, then released, then driven to the "above" indication, then released again. This separates true hysteresis from a flag that simply follows one input, and the edge count at each step confirms the synchronizer depth.

// File: rtl/rtc_irq_status_pkg.sv
// Shared constants for the alarm interrupt status block.
// Assumes an 8-bit status word.
package rtc_irq_status_pkg;
    localparam int STAT_W      = 8;
    localparam int LOBAT_POS   = 6;
    localparam int IRQ_POS     = 0;
endpackage

// File: rtl/rtc_sync2.sv
// Two-flop synchronizer, one lane per bit.
// Assumes the inputs are level signals that change slowly compared to clk.
module rtc_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic meta_q, stab_q;
        // Two-stage capture of one asynchronous lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end
        assign sync_out[g] = stab_q;
    end
endmodule

// File: rtl/rtc_batt_hyst.sv
// Low-battery flag with two-threshold hysteresis.
// Assumes synchronized inputs. If both are active, "low" takes priority.
module rtc_batt_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic lobat
);
    // Set on low, clear on high, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        lobat <= 1'b0;
        else if (below_lo) lobat <= 1'b1;
        else if (above_hi) lobat <= 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_decode.sv
// Address decode for the alarm range and the status address.
// Assumes the alarm range is contiguous and starts at BASE.
module rtc_alarm_decode #(
    parameter int ADDR_W = 8,
    parameter int BASE   = 8,
    parameter int COUNT  = 4,
    parameter int STAT   = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              alarm_acc,
    output logic              stat_sel
);
    localparam int LAST = BASE + COUNT - 1;
    logic in_range;
    // Range check over the alarm addresses.
    always_comb begin
        in_range = (int'(addr) >= BASE) && (int'(addr) <= LAST);
    end
    assign alarm_acc = in_range && (rd || wr);
    assign stat_sel  = (int'(addr) == STAT);
endmodule

// File: rtl/rtc_irq_flag.sv
// Interrupt request flag: set by a match, cleared by an alarm access.
// Assumes that a set wins over a clear on the same edge.
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_irq_status.sv
// Top: status register, request flag, interrupt gating, battery flag.
// Assumes alarm_hit is synchronous to clk and lasts one cycle per event.
module rtc_irq_status
    import rtc_irq_status_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 12,
    parameter int ALARM_COUNT = 4,
    parameter int ALARM_BASE  = STATUS_ADDR - ALARM_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_hit,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              irq_en,
    input  logic              batt_ok_in,
    input  logic              batt_low_in,
    output logic [STAT_W-1:0] status_rdata,
    output logic              irq_out
);
    logic       alarm_acc, stat_sel, irq_flag_q, lobat_q;
    logic [1:0] batt_sync;

    rtc_alarm_decode #(
        .ADDR_W(ADDR_W), .BASE(ALARM_BASE), .COUNT(ALARM_COUNT), .STAT(STATUS_ADDR)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .alarm_acc(alarm_acc), .stat_sel(stat_sel)
    );

    rtc_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(alarm_hit), .clr_i(alarm_acc), .flag(irq_flag_q)
    );

    rtc_sync2 #(.WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({batt_low_in, batt_ok_in}), .sync_out(batt_sync)
    );

    rtc_batt_hyst u_hyst (
        .clk(clk), .rst_n(rst_n),
        .above_hi(batt_sync[0]), .below_lo(batt_sync[1]), .lobat(lobat_q)
    );

    // Assemble the status word and gate it with the address select.
    always_comb begin
        status_rdata = '0;
        if (stat_sel) begin
            status_rdata[LOBAT_POS] = lobat_q;
            status_rdata[IRQ_POS]   = irq_flag_q;
        end
    end

    assign irq_out = irq_flag_q & irq_en;
endmodule

// File: rtl/rtc_irq_status_chk.sv
// Checker for rtc_irq_status, bound to every instance.
// Assumes default parameters for the address decode.
module rtc_irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alarm_hit,
    input logic [7:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       irq_en,
    input logic       irq_out,
    input logic       irq_flag_q,
    input logic       lobat_q
);
    logic acc_alarm;
    assign acc_alarm = (bus_addr >= 8'h08) && (bus_addr <= 8'h0B) && (bus_rd || bus_wr);

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> irq_flag_q);
    p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_out);
    p_gate_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && irq_flag_q) |-> irq_out);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_alarm && !alarm_hit) |=> !irq_flag_q);
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_alarm && !alarm_hit) |=> $stable(irq_flag_q));
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (!irq_flag_q && !lobat_q));
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .alarm_hit(alarm_hit), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .irq_en(irq_en), .irq_out(irq_out),
    .irq_flag_q(irq_flag_q), .lobat_q(lobat_q)
);

// File: tb/rtc_irq_status_tb.sv
// Directed bench for rtc_irq_status.
module rtc_irq_status_tb;
    localparam int CLK_PERIOD = 10;
    logic       clk = 1'b0, rst_n = 1'b0, alarm_hit = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0, bus_wr = 1'b0, irq_en = 1'b0;
    logic       batt_ok_in = 1'b0, batt_low_in = 1'b0;
    logic [7:0] status_rdata;
    logic       irq_out;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_status u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edge_n(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic status_is(input string req, input logic [7:0] exp);
        bus_addr = 8'h0C; bus_rd = 1'b0; bus_wr = 1'b0;
        #1 chk(req, status_rdata, exp);
    endtask

    task automatic access(input logic [7:0] a, input logic rd, input logic wr, input logic hit);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; alarm_hit = hit;
        edge_n(1);
        bus_rd = 1'b0; bus_wr = 1'b0; alarm_hit = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0; edge_n(2); rst_n = 1'b1;
        status_is("R8 reset status", 8'h00);
        chk("R3 reset irq", {7'd0, irq_out}, 8'h00);
        bus_addr = 8'h05; #1 chk("R1 other addr", status_rdata, 8'h00);
    endtask

    task automatic t_set_gate;
        irq_en = 1'b0;
        access(8'h00, 1'b0, 1'b0, 1'b1);
        status_is("R2 flag set", 8'h01);
        chk("R3 gated off", {7'd0, irq_out}, 8'h00);
        irq_en = 1'b1; #1;
        chk("R3 gated on", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_clear;
        access(8'h08, 1'b1, 1'b0, 1'b0);
        status_is("R4 read clears", 8'h00);
        chk("R3 irq drops", {7'd0, irq_out}, 8'h00);
        access(8'h00, 1'b0, 1'b0, 1'b1);
        access(8'h0B, 1'b0, 1'b1, 1'b0);
        status_is("R4 write clears", 8'h00);
    endtask

    task automatic t_no_clear;
        access(8'h00, 1'b0, 1'b0, 1'b1);
        access(8'h07, 1'b1, 1'b1, 1'b0);
        status_is("R6 outside range", 8'h01);
        access(8'h0C, 1'b1, 1'b0, 1'b0);
        status_is("R6 status read", 8'h01);
        access(8'h0C, 1'b0, 1'b1, 1'b0);
        status_is("R6 status write", 8'h01);
    endtask

    task automatic t_priority;
        access(8'h08, 1'b1, 1'b0, 1'b0);
        access(8'h09, 1'b1, 1'b0, 1'b1);
        status_is("R5 set wins", 8'h01);
        access(8'h09, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_battery;
        @(negedge clk); batt_low_in = 1'b1;
        edge_n(2); status_is("R7 not yet low", 8'h00);
        edge_n(1); status_is("R7 low after 3", 8'h40);
        access(8'h0C, 1'b0, 1'b1, 1'b0);
        status_is("R6 write keeps lobat", 8'h40);
        @(negedge clk); batt_low_in = 1'b0;
        edge_n(5); status_is("R7 hold low", 8'h40);
        @(negedge clk); batt_ok_in = 1'b1;
        edge_n(3); status_is("R7 cleared", 8'h00);
        @(negedge clk); batt_ok_in = 1'b0;
        edge_n(5); status_is("R7 hold ok", 8'h00);
        @(negedge clk); batt_ok_in = 1'b1; batt_low_in = 1'b1;
        edge_n(3); status_is("R7 low wins", 8'h40);
        @(negedge clk); batt_ok_in = 1'b0; batt_low_in = 1'b0;
        access(8'h00, 1'b0, 1'b0, 1'b1);
        @(negedge clk); rst_n = 1'b0; edge_n(1); rst_n = 1'b1;
        status_is("R8 reset clears both", 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_set_gate();
                t_clear();
                t_no_clear();
                t_priority();
                t_battery();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule